// File: doc/BRIEF.md
# Floating-Point Compare and Branch Condition Unit

This block compares two single-precision IEEE-754 operands and reduces the result to a 2-bit condition code. The code says whether operand A is equal to, less than or greater than operand B, or whether the two are unordered. The code is stored in a register that changes only on a cycle where the compare strobe is high. In the other cycles the register keeps the last result.

A 4-bit selector picks one of sixteen branch conditions. Each condition is taken for a fixed set of the four outcomes. The taken bit is combinational. When a compare is strobed in the same cycle as the branch, the branch uses the new compare result and not the stored code, so a compare followed at once by a branch needs no stall.

Top module: `fcmp_branch`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the stored code is Equal. The code values are Equal=0, Less=1, Greater=2 and Unordered=3.
- R2: An operand is a NaN when its exponent field [30:23] is all ones and its mantissa field [22:0] is non-zero. Any compare with a NaN operand stores Unordered.
- R3: Positive zero and negative zero compare Equal, in either order.
- R4: The order is always signed. A negative non-zero operand is Less than a positive operand, and bit 31 is the sign.
- R5: When both operands are negative, the larger magnitude is the Less one.
- R6: Infinities (exponent all ones, mantissa zero) are ordered values and are not NaNs. +inf is Greater than the largest finite value, and two equal infinities compare Equal.
- R7: When the compare strobe is low, the stored code does not change.
- R8: Selector bit 3 enables the branch on Equal, bit 2 on Less, bit 1 on Greater and bit 0 on Unordered. The branch is taken when the bit for the current outcome is set.
- R9: When the compare strobe is high, the taken bit uses the outcome computed in that same cycle. When the strobe is low, it uses the stored code.
- R10: The less-or-greater condition (selector 6) is not taken on Unordered. The not-equal condition (selector 7) is taken on Unordered.
- R11: Selector 0 is never taken and selector 15 is always taken, whatever the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Compare strobe; loads the new outcome |
| op_a | input | 32 | First single-precision operand |
| op_b | input | 32 | Second single-precision operand |
| cond_sel | input | 4 | Branch condition selector |
| fcc_q | output | 2 | Stored condition code |
| take | output | 1 | Branch taken for the selected condition |

## Verification
The bench compares signed zeros. A design that compares raw bits would report Greater or Less here instead of Equal. It orders pairs of negative values, where a design without the reversed magnitude order inverts the outcome. It also compares infinities against NaNs with a one in the lowest mantissa bit, where a loose NaN test would mislabel one as the other. The bench sets the less-or-greater and not-equal selectors against an Unordered outcome, steps through all sixteen selectors, and strobes a compare on the same cycle as a branch. A design without forwarding takes the branch from the stale code, and a design that ignores the strobe overwrites the held code.

// File: rtl/fcmp_branch.sv
module fcmp_branch (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmp_valid,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic [3:0]  cond_sel,
  output logic [1:0]  fcc_q,
  output logic        take
);
  localparam logic [1:0] FCC_EQ = 2'd0;
  localparam logic [1:0] FCC_LT = 2'd1;
  localparam logic [1:0] FCC_GT = 2'd2;
  localparam logic [1:0] FCC_UN = 2'd3;

  logic nan_a, nan_b, both_zero, mag_lt;
  logic [1:0] fcc_new, fcc_eff;

  assign nan_a     = (&op_a[30:23]) && (|op_a[22:0]);
  assign nan_b     = (&op_b[30:23]) && (|op_b[22:0]);
  assign both_zero = (op_a[30:0] == 31'd0) && (op_b[30:0] == 31'd0);
  assign mag_lt    = op_a[30:0] < op_b[30:0];

  always_comb begin
    if (nan_a || nan_b)             fcc_new = FCC_UN;
    else if (both_zero)             fcc_new = FCC_EQ;
    else if (op_a == op_b)          fcc_new = FCC_EQ;
    else if (op_a[31] != op_b[31])  fcc_new = op_a[31] ? FCC_LT : FCC_GT;
    else if (op_a[31])              fcc_new = mag_lt ? FCC_GT : FCC_LT;
    else                            fcc_new = mag_lt ? FCC_LT : FCC_GT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         fcc_q <= FCC_EQ;
    else if (cmp_valid) fcc_q <= fcc_new;
  end

  assign fcc_eff = cmp_valid ? fcc_new : fcc_q;
  assign take    = cond_sel[~fcc_eff];

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> $stable(fcc_q));
  assert_nan_unord_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && (nan_a || nan_b)) |=> fcc_q == FCC_UN);
  assert_zero_eq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && both_zero) |=> fcc_q == FCC_EQ);
  assert_sign_lt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !nan_a && !nan_b && !both_zero && op_a[31] && !op_b[31]) |=> fcc_q == FCC_LT);
  assert_never_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 4'd0) |-> !take);
  assert_always_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 4'd15) |-> take);
  assert_lg_unord_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 4'd6 && cmp_valid && (nan_a || nan_b)) |-> !take);
endmodule

// File: tb/fcmp_branch_tb.sv
module fcmp_branch_tb_top;
  logic clk = 0, rst_n = 0, cmp_valid = 0;
  logic [31:0] op_a = 0, op_b = 0;
  logic [3:0] cond_sel = 0;
  logic [1:0] fcc_q;
  logic take;
  int total = 0, bad = 0;
  logic [1:0] model_fcc = 2'd0;
  bit done = 0;

  typedef struct { logic [1:0] fcc; logic tk; string req; } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  fcmp_branch dut_i (.clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .op_a(op_a),
    .op_b(op_b), .cond_sel(cond_sel), .fcc_q(fcc_q), .take(take));

  function automatic logic [1:0] ref_cmp(logic [31:0] a, logic [31:0] b);
    bit na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    bit nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    if (na || nb) return 2'd3;
    if (a[30:0] == 0 && b[30:0] == 0) return 2'd0;
    if (a == b) return 2'd0;
    if (a[31] && !b[31]) return 2'd1;
    if (!a[31] && b[31]) return 2'd2;
    if (!a[31]) return (a[30:0] < b[30:0]) ? 2'd1 : 2'd2;
    return (a[30:0] > b[30:0]) ? 2'd1 : 2'd2;
  endfunction

  function automatic logic ref_take(logic [3:0] sel, logic [1:0] f);
    case (f)
      2'd0: return sel[3];
      2'd1: return sel[2];
      2'd2: return sel[1];
      default: return sel[0];
    endcase
  endfunction

  task automatic drive(logic [31:0] a, logic [31:0] b, logic v, logic [3:0] sel, string req);
    item_t it;
    logic [1:0] f;
    @(negedge clk);
    op_a = a; op_b = b; cmp_valid = v; cond_sel = sel;
    f = v ? ref_cmp(a, b) : model_fcc;
    model_fcc = f;
    it.fcc = f; it.tk = ref_take(sel, f); it.req = req;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk); #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        total++;
        if (take !== it.tk) begin bad++; $display("FAIL %s take act=%0b exp=%0b", it.req, take, it.tk); end
        @(posedge clk); #1;
        total++;
        if (fcc_q !== it.fcc) begin bad++; $display("FAIL %s fcc act=%0d exp=%0d", it.req, fcc_q, it.fcc); end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1; total++;
    if (fcc_q !== 2'd0) begin bad++; $display("FAIL R1 reset act=%0d exp=0", fcc_q); end
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1; total++;
    if (fcc_q !== 2'd0) begin bad++; $display("FAIL R1 post-reset act=%0d exp=0", fcc_q); end
    drive(32'h3F800000, 32'h40000000, 1, 4'd4, "R4");
    drive(32'h40000000, 32'h3F800000, 1, 4'd2, "R4");
    drive(32'hBF800000, 32'h3F800000, 1, 4'd4, "R4");
    drive(32'h80000000, 32'h00000000, 1, 4'd8, "R3");
    drive(32'h00000000, 32'h80000000, 1, 4'd7, "R3");
    drive(32'hC0000000, 32'hBF800000, 1, 4'd4, "R5");
    drive(32'hBF800000, 32'hC0000000, 1, 4'd2, "R5");
    drive(32'h7F800000, 32'h7F7FFFFF, 1, 4'd2, "R6");
    drive(32'hFF800000, 32'hFF800000, 1, 4'd8, "R6");
    drive(32'h7F800001, 32'h3F800000, 1, 4'd6, "R2 R10");
    drive(32'h3F800000, 32'h7FC00000, 1, 4'd7, "R2 R10");
    drive(32'h40000000, 32'h3F800000, 0, 4'd1, "R7");
    drive(32'h00000000, 32'h00000000, 0, 4'd8, "R7");
    for (int s = 0; s < 16; s++) drive(32'h0, 32'h0, 0, s[3:0], "R8 R11");
    drive(32'h3F800000, 32'h3F800000, 1, 4'd8, "R8");
    for (int s = 0; s < 16; s++) drive(32'h0, 32'h0, 0, s[3:0], "R8 R11");
    drive(32'h40000000, 32'h3F800000, 1, 4'd2, "R9");
    drive(32'h3F800000, 32'h40000000, 1, 4'd4, "R9");
    drive(32'h3F800000, 32'h40000000, 1, 4'd2, "R9");
    drive(32'h7F800000, 32'h7F800000, 1, 4'd15, "R11");
    drive(32'h7F800000, 32'h7F800001, 1, 4'd0, "R11");
    drive(32'h0, 32'h0, 0, 4'd0, "R7");
    @(negedge clk); cmp_valid = 0;
    wait (q.size() == 0);
    repeat (3) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule